// File: doc/BRIEF.md
# Shared Private Peripheral Window Decoder

This block sits in front of a 4 KB private peripheral window that up to four processors share. Each access arrives on a simple single-cycle bus. The bus carries a 12-bit window offset and a sideband input naming the requesting CPU. The block sorts each access into one of three places:

- a handful of system control registers that it holds itself;
- the interrupt-interface bank of one CPU;
- one of the private timers, where each CPU owns a timer and a watchdog.

For the downstream slaves it produces a select, a bank or timer index and a local offset. For a read it returns the data one cycle later.

Each CPU reaches its own resources in two ways. An alias page resolves to the bank of the requester. There is also an explicitly numbered page per CPU. A numbered page whose CPU is not present is read as zero, and writes to it are dropped. Offsets that decode to nothing raise a one-cycle error flag. The block also carries each timer's and each watchdog's interrupt line to the private interrupt inputs of the CPU that owns it.

Top module: `priv_window_decode`

## Requirements
- R1: After synchronous reset, rsp_rdata and rsp_err are zero, gic_sel and tmr_sel are low, and the stored control bit is 0.
- R2: A write to offset 0x000 stores data bit 0 only. A later read of 0x000 returns that bit in bit 0, with bits 31:1 zero.
- R3: A read of offset 0x004 returns ((2^NUM_CPU)-1)<<4 | (NUM_CPU-1). Bits 7:4 form the present-CPU mask and bits 1:0 hold the count minus one.
- R4: Reads of 0x008 and 0x00C return zero. A write to 0x00C is accepted without error and leaves the control bit unchanged.
- R5: Offsets 0x100-0x1FF select the interrupt interface (gic_sel) of the CPU given on req_cpu, with gic_off = offset[7:0].
- R6: Offsets 0x200-0x5FF select the interrupt interface of CPU offset[11:8]-2, with gic_off = offset[7:0]. A read returns gic_rdata one cycle later.
- R7: Offsets 0x600-0x6FF select the timers (tmr_sel) of the requesting CPU. tmr_idx = 2*cpu + offset[5], where offset[5]=1 means the watchdog, and tmr_off = offset[3:0].
- R8: Offsets 0x700-0xAFF select the timers of CPU offset[11:8]-7, with the same index and offset rule as R7. A read returns tmr_rdata one cycle later.
- R9: An access that resolves to a CPU number of NUM_CPU or above asserts no select and no error, and a read of it returns zero.
- R10: rsp_err is high for exactly the cycle after any of these accesses, and reads of them return zero:
  - any access at 0xB00-0xFFF;
  - any system-range offset other than 0x000, 0x004, 0x008 and 0x00C;
  - a write to 0x004 or 0x008.
- R11: tmr_irq[2c] drives ppi_timer[c] (private interrupt 29 of CPU c). tmr_irq[2c+1] drives ppi_wdog[c] (private interrupt 30 of CPU c).
- R12: rsp_rdata is registered. It carries the read data of the access from the previous cycle, and it is zero after a write or an idle cycle.
- R13: dn_write and dn_wdata pass req_write and req_wdata through to the downstream slaves unchanged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Offset within the 4 KB window |
| req_cpu | input | 2 | Index of the requesting CPU |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the access |
| rsp_err | output | 1 | Undefined-offset flag, one cycle after the access |
| dn_write | output | 1 | Write strobe passed to the slaves |
| dn_wdata | output | 32 | Write data passed to the slaves |
| gic_sel | output | 1 | Interrupt-interface bank select |
| gic_cpu | output | 2 | Interrupt-interface bank number |
| gic_off | output | 8 | Interrupt-interface local offset |
| gic_rdata | input | 32 | Interrupt-interface read data, same cycle |
| tmr_sel | output | 1 | Timer select |
| tmr_idx | output | 3 | Timer number, 2*cpu + watchdog bit |
| tmr_off | output | 4 | Timer register offset |
| tmr_rdata | input | 32 | Timer read data, same cycle |
| tmr_irq | input | 2*NUM_CPU | Timer (even) and watchdog (odd) interrupt lines |
| ppi_timer | output | NUM_CPU | Private interrupt 29 per CPU |
| ppi_wdog | output | NUM_CPU | Private interrupt 30 per CPU |

## Verification
The bench builds the block with NUM_CPU = 3. With this value, numbered page 3 in both the interrupt and the timer ranges belongs to an absent CPU, so the drop rule can be exercised. It also lets the alias pages be driven with a requester index that is not present. Three also makes the configuration word 0x72, a value no power-of-two count gives. A different count, a swapped mask or a count field that is off by one all show up in that word.

// File: rtl/priv_win_pkg.sv
// Package: types and constants shared by the private window decoder.
// Assumes a window of 4 KB and at most four CPUs, so a CPU number fits in 2 bits.
package priv_win_pkg;
    localparam int OFF_W  = 12;
    localparam int CPU_W  = 2;
    localparam int DATA_W = 32;

    // Offsets of the system control registers inside the first page.
    localparam logic [7:0] SYS_CTRL = 8'h00;
    localparam logic [7:0] SYS_CFG  = 8'h04;
    localparam logic [7:0] SYS_STAT = 8'h08;
    localparam logic [7:0] SYS_INV  = 8'h0C;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SYS,
        RG_IRQ,
        RG_TMR,
        RG_BAD
    } region_e;

    typedef struct packed {
        region_e           region;
        logic [CPU_W-1:0]  cpu;
        logic              present;
    } dec_t;
endpackage

// File: rtl/priv_addr_decode.sv
// Module: purely combinational page decoder.
// Sorts an access into system, interrupt-interface, timer or undefined space,
// resolves alias pages to the requester, and flags CPUs that are not present.
// Assumes the offset is already reduced to the 4 KB window.
module priv_addr_decode
    import priv_win_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic             acc_valid,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [CPU_W-1:0] acc_cpu,
    output dec_t             dec
);
    logic [3:0] page;
    assign page = acc_off[OFF_W-1:8];

    // Map the page number to a region and to a target CPU.
    always_comb begin
        dec.region = RG_NONE;
        dec.cpu    = acc_cpu;
        if (acc_valid) begin
            if (page == 4'h0) begin
                dec.region = RG_SYS;
            end else if (page == 4'h1) begin
                dec.region = RG_IRQ;
            end else if (page <= 4'h5) begin
                dec.region = RG_IRQ;
                dec.cpu    = CPU_W'(page - 4'h2);
            end else if (page == 4'h6) begin
                dec.region = RG_TMR;
            end else if (page <= 4'hA) begin
                dec.region = RG_TMR;
                dec.cpu    = CPU_W'(page - 4'h7);
            end else begin
                dec.region = RG_BAD;
            end
        end
        dec.present = (int'(dec.cpu) < NUM_CPU);
    end
endmodule

// File: rtl/priv_sysctl.sv
// Module: system control register group held inside the decoder.
// Holds the single stored control bit and forms the read value and the
// undefined-offset flag for the system page. Assumes acc_en is high only
// for a valid access that falls in the system page.
module priv_sysctl
    import priv_win_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_write,
    input  logic [7:0]        acc_off,
    input  logic              wbit,
    output logic [DATA_W-1:0] rdata,
    output logic              bad
);
    localparam logic [DATA_W-1:0] CFG_WORD =
        DATA_W'(((1 << NUM_CPU) - 1) << 4) | DATA_W'(NUM_CPU - 1);

    logic ctrl_q;

    // Store bit 0 of a write to the control offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 1'b0;
        else if (acc_en && acc_write && acc_off == SYS_CTRL)
            ctrl_q <= wbit;
    end

    // Form the read value and flag undefined or read-only targets.
    always_comb begin
        rdata = '0;
        bad   = 1'b0;
        case (acc_off)
            SYS_CTRL: rdata = {{(DATA_W-1){1'b0}}, ctrl_q};
            SYS_CFG:  begin rdata = CFG_WORD; bad = acc_write; end
            SYS_STAT: bad = acc_write;
            SYS_INV:  bad = 1'b0;
            default:  bad = 1'b1;
        endcase
        if (!acc_en) bad = 1'b0;
    end
endmodule

// File: rtl/priv_ppi_route.sv
// Module: routes each timer and watchdog interrupt to its owning CPU.
// Even lines are timers (private interrupt 29), odd lines are watchdogs (30).
module priv_ppi_route #(
    parameter int NUM_CPU = 4
) (
    input  logic [2*NUM_CPU-1:0] tmr_irq,
    output logic [NUM_CPU-1:0]   ppi_timer,
    output logic [NUM_CPU-1:0]   ppi_wdog
);
    // One pair of lines per CPU.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign ppi_timer[c] = tmr_irq[2*c];
        assign ppi_wdog[c]  = tmr_irq[2*c+1];
    end
endmodule

// File: rtl/priv_window_decode.sv
// Module: top of the shared private peripheral window decoder.
// Drives slave selects in the access cycle and returns read data and the
// error flag one cycle later. Assumes the slaves return read data in the same
// cycle as the select, and that NUM_CPU is between 1 and 4.
module priv_window_decode
    import priv_win_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [11:0]          req_addr,
    input  logic [1:0]           req_cpu,
    input  logic [31:0]          req_wdata,
    output logic [31:0]          rsp_rdata,
    output logic                 rsp_err,
    output logic                 dn_write,
    output logic [31:0]          dn_wdata,
    output logic                 gic_sel,
    output logic [1:0]           gic_cpu,
    output logic [7:0]           gic_off,
    input  logic [31:0]          gic_rdata,
    output logic                 tmr_sel,
    output logic [2:0]           tmr_idx,
    output logic [3:0]           tmr_off,
    input  logic [31:0]          tmr_rdata,
    input  logic [2*NUM_CPU-1:0] tmr_irq,
    output logic [NUM_CPU-1:0]   ppi_timer,
    output logic [NUM_CPU-1:0]   ppi_wdog
);
    dec_t              dec;
    logic [DATA_W-1:0] sys_rdata;
    logic              sys_bad;
    logic [DATA_W-1:0] rd_mux;
    logic              err_now;

    priv_addr_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .acc_valid (req_valid),
        .acc_off   (req_addr),
        .acc_cpu   (req_cpu),
        .dec       (dec)
    );

    priv_sysctl #(.NUM_CPU(NUM_CPU)) u_sys (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (dec.region == RG_SYS),
        .acc_write (req_write),
        .acc_off   (req_addr[7:0]),
        .wbit      (req_wdata[0]),
        .rdata     (sys_rdata),
        .bad       (sys_bad)
    );

    priv_ppi_route #(.NUM_CPU(NUM_CPU)) u_ppi (
        .tmr_irq   (tmr_irq),
        .ppi_timer (ppi_timer),
        .ppi_wdog  (ppi_wdog)
    );

    // Slave-side signals: selects gated by presence, offsets passed straight on.
    assign gic_sel  = (dec.region == RG_IRQ) && dec.present;
    assign gic_cpu  = dec.cpu;
    assign gic_off  = req_addr[7:0];
    assign tmr_sel  = (dec.region == RG_TMR) && dec.present;
    assign tmr_idx  = {dec.cpu, req_addr[5]};
    assign tmr_off  = req_addr[3:0];
    assign dn_write = req_write;
    assign dn_wdata = req_wdata;

    // Pick the read source for the current access.
    always_comb begin
        rd_mux = '0;
        if (dec.region == RG_SYS)
            rd_mux = sys_rdata;
        else if (gic_sel)
            rd_mux = gic_rdata;
        else if (tmr_sel)
            rd_mux = tmr_rdata;
    end

    assign err_now = (dec.region == RG_BAD) || sys_bad;

    // Register the response one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_rdata <= (req_valid && !req_write && !err_now) ? rd_mux : '0;
            rsp_err   <= err_now;
        end
    end
endmodule

// File: rtl/priv_window_checker.sv
// Module: property checker for the window decoder, attached through bind.
// Observes ports only; assumes the synchronous active-low reset of the top.
module priv_window_checker #(
    parameter int NUM_CPU = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [11:0] req_addr,
    input logic [1:0]  req_cpu,
    input logic [31:0] rsp_rdata,
    input logic        rsp_err,
    input logic        gic_sel,
    input logic [1:0]  gic_cpu,
    input logic        tmr_sel,
    input logic [2:0]  tmr_idx
);
    localparam logic [31:0] CFG_EXP =
        32'(((1 << NUM_CPU) - 1) << 4) | 32'(NUM_CPU - 1);

    // R9: no select ever reaches an absent CPU
    a_r9_irq_present: assert property (@(posedge clk) disable iff (!rst_n)
        gic_sel |-> (int'(gic_cpu) < NUM_CPU));
    a_r9_tmr_present: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_sel |-> (int'(tmr_idx) < 2*NUM_CPU));
    // R7: at most one slave selected
    a_r7_one_slave: assert property (@(posedge clk) disable iff (!rst_n)
        !(gic_sel && tmr_sel));
    // R5: the alias page resolves to the requester
    a_r5_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11:8] == 4'h1 && int'(req_cpu) < NUM_CPU)
        |-> (gic_sel && gic_cpu == req_cpu));
    // R2: the control read carries one bit only
    a_r2_ctrl_width: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 12'h000) |=> (rsp_rdata[31:1] == 31'd0));
    // R3: the configuration word
    a_r3_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 12'h004) |=> (rsp_rdata == CFG_EXP));
    // R12: no read data after writes or idle cycles
    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_write) |=> (rsp_rdata == 32'd0));
    // R10: an error flag follows an access
    a_r10_err_src: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(req_valid));
endmodule

bind priv_window_decode priv_window_checker #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_cpu   (req_cpu),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .gic_sel   (gic_sel),
    .gic_cpu   (gic_cpu),
    .tmr_sel   (tmr_sel),
    .tmr_idx   (tmr_idx)
);

// File: tb/priv_window_decode_test.sv
`timescale 1ns/100ps
// Bench: behavioural reference model compared on every clock, NUM_CPU = 3.
module priv_window_decode_test;
    localparam int NC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_cpu = '0;
    logic [31:0] req_wdata = '0;
    logic [2*NC-1:0] tmr_irq = '0;
    logic [31:0] rsp_rdata, dn_wdata, gic_rdata, tmr_rdata;
    logic rsp_err, dn_write, gic_sel, tmr_sel;
    logic [1:0] gic_cpu;
    logic [7:0] gic_off;
    logic [2:0] tmr_idx;
    logic [3:0] tmr_off;
    logic [NC-1:0] ppi_timer, ppi_wdog;

    int checks = 0, fails = 0;
    string cur_tag = "R1";
    bit armed = 0, done = 0;
    int m_ctrl = 0;
    logic [31:0] e_rdata = '0;
    logic e_err = 1'b0;

    always #2.5 clk = ~clk;

    priv_window_decode #(.NUM_CPU(NC)) uut (.*);

    // Downstream stubs echo their select fields.
    assign gic_rdata = {16'hC1C0, 6'd0, gic_cpu, gic_off};
    assign tmr_rdata = {16'h7170, 9'd0, tmr_idx, tmr_off};

    // region: 0 idle, 1 system, 2 interrupt, 3 timer, 4 undefined
    function automatic void ref_decode(input logic v, input int o, input int rc,
                                       output int region, output int cpu);
        region = 0; cpu = rc;
        if (!v) return;
        if (o < 'h100) region = 1;
        else if (o < 'h200) region = 2;
        else if (o < 'h600) begin region = 2; cpu = (o - 'h200) / 256; end
        else if (o < 'h700) region = 3;
        else if (o < 'hB00) begin region = 3; cpu = (o - 'h700) / 256; end
        else region = 4;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    // Reference model of the registered response and the control bit.
    always @(posedge clk) begin
        int region, cpu, o;
        o = int'(req_addr);
        if (!rst_n) begin
            m_ctrl = 0; e_rdata = '0; e_err = 1'b0;
        end else begin
            ref_decode(req_valid, o, int'(req_cpu), region, cpu);
            e_rdata = '0;
            e_err = (region == 4) ||
                    (region == 1 && !(o == 0 || o == 4 || o == 8 || o == 'hC)) ||
                    (region == 1 && req_write && (o == 4 || o == 8));
            if (req_valid && !req_write && !e_err) begin
                if (region == 1 && o == 0) e_rdata = m_ctrl;
                else if (region == 1 && o == 4) e_rdata = 32'h72;
                else if (region == 2 && cpu < NC) e_rdata = 32'hC1C0_0000 | (cpu << 8) | (o % 256);
                else if (region == 3 && cpu < NC)
                    e_rdata = 32'h7170_0000 | ((cpu * 2 + (o / 32) % 2) << 4) | (o % 16);
            end
            if (region == 1 && req_write && o == 0) m_ctrl = req_wdata[0];
        end
        armed = 1;
    end

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        int region, cpu, o;
        if (armed && !done) begin
            o = int'(req_addr);
            ref_decode(req_valid, o, int'(req_cpu), region, cpu);
            chk("rsp_rdata", rsp_rdata, e_rdata);
            chk("rsp_err", 32'(rsp_err), 32'(e_err));
            chk("gic_sel", 32'(gic_sel), 32'(region == 2 && cpu < NC));
            chk("tmr_sel", 32'(tmr_sel), 32'(region == 3 && cpu < NC));
            if (region == 2 && cpu < NC) begin
                chk("gic_cpu", 32'(gic_cpu), 32'(cpu));
                chk("gic_off", 32'(gic_off), 32'(o % 256));
            end
            if (region == 3 && cpu < NC) begin
                chk("tmr_idx", 32'(tmr_idx), 32'(cpu * 2 + (o / 32) % 2));
                chk("tmr_off", 32'(tmr_off), 32'(o % 16));
            end
            chk("dn_write R13", 32'(dn_write), 32'(req_write));
            chk("dn_wdata R13", dn_wdata, req_wdata);
            for (int c = 0; c < NC; c++) begin
                chk("ppi_timer R11", 32'(ppi_timer[c]), 32'(tmr_irq[2*c]));
                chk("ppi_wdog R11", 32'(ppi_wdog[c]), 32'(tmr_irq[2*c+1]));
            end
        end
    end

    task automatic acc(input string tag, input logic w, input int a,
                       input int rc, input logic [31:0] d);
        @(posedge clk); #1;
        cur_tag = tag;
        req_valid = 1'b1; req_write = w; req_addr = 12'(a);
        req_cpu = 2'(rc); req_wdata = d;
    endtask

    task automatic idle(input string tag);
        @(posedge clk); #1;
        cur_tag = tag;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        #(20000 * 5);
        if (!done) begin
            done = 1; checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle("R1");
        acc("R3", 0, 'h004, 0, 0);
        acc("R2", 1, 'h000, 1, 32'hFFFF_FFFF);
        acc("R2", 0, 'h000, 1, 0);
        acc("R4", 1, 'h00C, 0, 32'h0);
        acc("R4", 0, 'h000, 2, 0);
        acc("R4", 0, 'h008, 0, 0);
        acc("R4", 0, 'h00C, 0, 0);
        acc("R2", 1, 'h000, 0, 32'hFFFF_FFFE);
        acc("R2", 0, 'h000, 0, 0);
        for (int c = 0; c < 4; c++) acc("R5", 0, 'h100 + 4 * c + 16 * c, c, 0);
        acc("R12", 1, 'h1F8, 1, 32'hDEAD_BEEF);
        idle("R12");
        for (int c = 0; c < 4; c++) acc("R6", 0, 'h200 + 256 * c + 8 * c + 3, 2, 0);
        for (int c = 0; c < 4; c++) begin
            acc("R7", 0, 'h600 + 4 * c, c, 0);
            acc("R7", 0, 'h620 + 4 * c, c, 0);
        end
        for (int c = 0; c < 4; c++) begin
            acc("R8", 0, 'h704 + 256 * c, 0, 0);
            acc("R8", 0, 'h72C + 256 * c, 1, 0);
        end
        acc("R9", 0, 'h510, 0, 0);
        acc("R9", 1, 'hA20, 0, 32'h1234_5678);
        acc("R9", 0, 'hA28, 2, 0);
        acc("R10", 0, 'h010, 0, 0);
        acc("R10", 1, 'h004, 0, 32'h1);
        acc("R10", 1, 'h008, 0, 32'h1);
        acc("R10", 0, 'hB00, 0, 0);
        acc("R10", 1, 'hFFC, 1, 32'h5);
        acc("R3", 0, 'h004, 2, 0);
        idle("R11");
        for (int p = 0; p < 2 * NC; p++) begin
            @(posedge clk); #1 tmr_irq = (2*NC)'(1 << p);
        end
        @(posedge clk); #1 tmr_irq = '1;
        @(posedge clk); #1 tmr_irq = (2*NC)'('b010110);
        idle("R12");
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule